// File: doc/BRIEF.md
# Group Completion Tracker

This block keeps in-flight micro-operations in program order, one table slot per dispatched group instead of one per uop. A dispatcher offers at most one group per cycle, described by a three-bit mask of occupied uop positions. The block answers with the slot tag, which then travels with every uop of that group through execution.

Execution units report finished uops with the slot tag, the uop position inside the group, and an exception flag. Several such reports may arrive in one cycle. The oldest slot retires, all or nothing, once every occupied uop position in it has reported. The retirement is published on a registered completion interface that carries the tag and an exception bit. A retiring group that carries an exception discards every younger group. A flush input discards everything.

Top module: `grp_cmpl_table`

## Requirements
- R1: After reset the table is empty (`tbl_empty`=1, `tbl_full`=0), `alloc_ready`=1, `alloc_tag`=0 and `cmp_valid`=0.
- R2: Each accepted allocation takes the tag shown on `alloc_tag` in that cycle. Tags run 0,1,...,ENTRIES-1 and then wrap to 0, and at most one group is taken per cycle.
- R3: With ENTRIES slots occupied, `tbl_full`=1 and `alloc_ready`=0. An offered group is then not taken, and the table stays full.
- R4: A group does not retire until every uop position set in its mask has reported. `cmp_valid` rises on the clock edge after the edge that recorded the last missing report.
- R5: Groups retire strictly in allocation order. A younger group that has finished waits for all older ones.
- R6: At most one group retires per cycle. Groups that are already finished retire on consecutive cycles.
- R7: A finish report has no effect on state when it names a uop position not set in its group's mask, or a position index of 3 or more, or a slot that is not occupied. Its exception flag is ignored as well.
- R8: Up to NFIN finish reports in one cycle are all recorded. Report k uses `fin_tag[k*5 +: 5]`, `fin_uop[k*2 +: 2]`, `fin_exc[k]` and `fin_valid[k]`.
- R9: A group with any reported exception retires with `cmp_exc`=1. In the cycle before that retirement, `alloc_ready`=0. After it the table is empty, no younger group ever retires, and `alloc_tag` is the tag following the retired one.
- R10: A cycle with `flush`=1 empties the table, sets `alloc_tag` to 0 and suppresses any retirement from that cycle.
- R11: `cmp_tag` equals the tag the group was given at allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all groups |
| alloc_valid | input | 1 | Dispatcher offers a group |
| alloc_mask | input | 3 | Occupied uop positions of the offered group |
| alloc_ready | output | 1 | A group can be taken this cycle |
| alloc_tag | output | 5 | Tag given to the group taken this cycle |
| fin_valid | input | 5 | Per-report valid |
| fin_tag | input | 25 | Per-report slot tag, 5 bits each |
| fin_uop | input | 10 | Per-report uop position, 2 bits each |
| fin_exc | input | 5 | Per-report exception flag |
| cmp_valid | output | 1 | A group retired (registered) |
| cmp_tag | output | 5 | Tag of the retired group |
| cmp_exc | output | 1 | Retired group carried an exception |
| tbl_empty | output | 1 | No slot occupied |
| tbl_full | output | 1 | All slots occupied |

## Verification
On every cycle, the assertions check the following. Occupancy never exceeds the slot count. A full table refuses groups. Recorded finishes stay inside the group mask. Consecutive retirements carry consecutive tags. An exception retirement or a flush leaves the table empty. Other behaviour needs the bench's scenarios. These are the exact cycle of retirement after the last report, partial groups held back, stray reports ignored, five reports in a single cycle, and younger groups discarded behind an exception.

// File: rtl/gct_pkg.sv
package gct_pkg;
  // Wrapping increment of a slot pointer over a table of n slots.
  function automatic int unsigned slot_inc(input int unsigned p, input int unsigned n);
    return (p == n - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/gct_slot.sv
module gct_slot #(
  parameter int IDX     = 0,
  parameter int UOPS    = 3,
  parameter int NFIN    = 5,
  parameter int TAG_W   = 5,
  parameter int UIDX_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    alloc_we,
  input  logic [UOPS-1:0]         alloc_mask,
  input  logic                    retire,
  input  logic [NFIN-1:0]         fin_valid,
  input  logic [NFIN*TAG_W-1:0]   fin_tag,
  input  logic [NFIN*UIDX_W-1:0]  fin_uop,
  input  logic [NFIN-1:0]         fin_exc,
  output logic                    occ,
  output logic                    exc_o,
  output logic                    done_all
);
  logic [UOPS-1:0] mask_q, done_q;
  logic [UOPS-1:0] hit_done;
  logic            hit_exc;

  // Decode all finish reports aimed at this slot; positions outside the mask drop out.
  always_comb begin
    hit_done = '0;
    hit_exc  = 1'b0;
    for (int k = 0; k < NFIN; k++) begin
      if (fin_valid[k] && fin_tag[k*TAG_W +: TAG_W] == TAG_W'(IDX)) begin
        for (int u = 0; u < UOPS; u++) begin
          if (fin_uop[k*UIDX_W +: UIDX_W] == UIDX_W'(u) && mask_q[u]) begin
            hit_done[u] = 1'b1;
            if (fin_exc[k]) hit_exc = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      occ    <= 1'b0;
      mask_q <= '0;
      done_q <= '0;
      exc_o  <= 1'b0;
    end else if (alloc_we) begin
      occ    <= 1'b1;
      mask_q <= alloc_mask;
      done_q <= '0;
      exc_o  <= 1'b0;
    end else if (retire) begin
      occ    <= 1'b0;
    end else if (occ) begin
      done_q <= done_q | hit_done;
      exc_o  <= exc_o | hit_exc;
    end
  end

  assign done_all = occ && ((done_q & mask_q) == mask_q);

  // R7: recorded finishes never leave the group's mask
  p_done_in_mask_r7: assert property (@(posedge clk) disable iff (rst)
    occ |-> ((done_q & ~mask_q) == '0));
  // R2: a fresh allocation starts with no finishes recorded
  p_alloc_fresh_r2: assert property (@(posedge clk) disable iff (rst)
    (alloc_we && !clr) |=> (occ && done_q == '0 && !exc_o));
endmodule

// File: rtl/gct_ptrs.sv
module gct_ptrs #(
  parameter int ENTRIES = 24,
  parameter int TAG_W   = 5,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             kill,
  input  logic             push,
  input  logic             pop,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [CNT_W-1:0] count
);
  import gct_pkg::*;

  logic [TAG_W-1:0] head_nx, tail_nx;
  assign head_nx = TAG_W'(slot_inc(int'(head), ENTRIES));
  assign tail_nx = TAG_W'(slot_inc(int'(tail), ENTRIES));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (kill) begin
      head  <= head_nx;
      tail  <= head_nx;
      count <= '0;
    end else begin
      if (push) tail <= tail_nx;
      if (pop)  head <= head_nx;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  // R3: occupancy never exceeds the slot count
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(ENTRIES));
  // R3: no group is taken into a full table
  p_full_no_push_r3: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_W'(ENTRIES)) |-> !push);
endmodule

// File: rtl/grp_cmpl_table.sv
module grp_cmpl_table #(
  parameter int ENTRIES = 24,
  parameter int UOPS    = 3,
  parameter int NFIN    = 5,
  localparam int TAG_W  = $clog2(ENTRIES),
  localparam int CNT_W  = $clog2(ENTRIES + 1),
  localparam int UIDX_W = $clog2(UOPS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush,
  input  logic                    alloc_valid,
  input  logic [UOPS-1:0]         alloc_mask,
  output logic                    alloc_ready,
  output logic [TAG_W-1:0]        alloc_tag,
  input  logic [NFIN-1:0]         fin_valid,
  input  logic [NFIN*TAG_W-1:0]   fin_tag,
  input  logic [NFIN*UIDX_W-1:0]  fin_uop,
  input  logic [NFIN-1:0]         fin_exc,
  output logic                    cmp_valid,
  output logic [TAG_W-1:0]        cmp_tag,
  output logic                    cmp_exc,
  output logic                    tbl_empty,
  output logic                    tbl_full
);
  import gct_pkg::*;

  logic [TAG_W-1:0]   head, tail;
  logic [CNT_W-1:0]   count;
  logic [ENTRIES-1:0] occ, exc_v, done_v;
  logic               can_ret, ret_exc, push, pop, kill;

  assign tbl_empty   = (count == '0);
  assign tbl_full    = (count == CNT_W'(ENTRIES));
  assign can_ret     = done_v[head];
  assign ret_exc     = can_ret && exc_v[head];
  assign alloc_ready = !tbl_full && !flush && !ret_exc;
  assign push        = alloc_valid && alloc_ready;
  assign pop         = can_ret && !flush;
  assign kill        = ret_exc && !flush;
  assign alloc_tag   = tail;

  gct_ptrs #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_ptrs (
    .clk(clk), .rst(rst), .clr(flush), .kill(kill), .push(push), .pop(pop),
    .head(head), .tail(tail), .count(count)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    gct_slot #(.IDX(i), .UOPS(UOPS), .NFIN(NFIN), .TAG_W(TAG_W), .UIDX_W(UIDX_W)) u_slot (
      .clk(clk), .rst(rst), .clr(flush || kill),
      .alloc_we(push && tail == TAG_W'(i)), .alloc_mask(alloc_mask),
      .retire(pop && head == TAG_W'(i)),
      .fin_valid(fin_valid), .fin_tag(fin_tag), .fin_uop(fin_uop), .fin_exc(fin_exc),
      .occ(occ[i]), .exc_o(exc_v[i]), .done_all(done_v[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cmp_valid <= 1'b0;
      cmp_tag   <= '0;
      cmp_exc   <= 1'b0;
    end else begin
      cmp_valid <= pop;
      cmp_tag   <= head;
      cmp_exc   <= ret_exc;
    end
  end

  // R5: back-to-back retirements carry consecutive tags
  p_in_order_r5: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && $past(cmp_valid)) |->
      (int'(cmp_tag) == int'(slot_inc(int'($past(cmp_tag)), ENTRIES))));
  // R9: an exception retirement leaves the table empty
  p_exc_empties_r9: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_exc) |-> (tbl_empty && occ == '0));
  // R10: flush empties the table and blocks completion
  p_flush_empties_r10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (tbl_empty && !cmp_valid && occ == '0));
  // R3: a full table refuses groups
  p_full_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    tbl_full |-> !alloc_ready);
endmodule

// File: tb/grp_cmpl_table_bench.sv
module grp_cmpl_table_bench;
  localparam int N = 24;
  logic clk = 1'b0, rst = 1'b1, flush = 1'b0, alloc_valid = 1'b0;
  logic [2:0] alloc_mask = '0;
  logic alloc_ready, cmp_valid, cmp_exc, tbl_empty, tbl_full;
  logic [4:0] alloc_tag, cmp_tag;
  logic [4:0] fin_valid = '0, fin_exc = '0;
  logic [24:0] fin_tag = '0;
  logic [9:0] fin_uop = '0;
  int errors = 0, checks = 0, exp_tag = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  grp_cmpl_table u_grp_cmpl_table (
    .clk(clk), .rst(rst), .flush(flush), .alloc_valid(alloc_valid), .alloc_mask(alloc_mask),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag), .fin_valid(fin_valid), .fin_tag(fin_tag),
    .fin_uop(fin_uop), .fin_exc(fin_exc), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .cmp_exc(cmp_exc), .tbl_empty(tbl_empty), .tbl_full(tbl_full)
  );

  typedef struct packed { logic [2:0] mask; logic [2:0] first; logic exc; } vec_t;
  localparam vec_t VECS [8] = '{
    '{3'b111, 3'b111, 1'b0}, '{3'b001, 3'b001, 1'b0}, '{3'b010, 3'b010, 1'b0},
    '{3'b101, 3'b001, 1'b0}, '{3'b110, 3'b100, 1'b0}, '{3'b011, 3'b011, 1'b1},
    '{3'b100, 3'b100, 1'b0}, '{3'b111, 3'b011, 1'b0}};

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_fin(); fin_valid = '0; fin_exc = '0; fin_tag = '0; fin_uop = '0; endtask

  task automatic add_fin(input int k, input int tag, input int uop, input bit exc);
    fin_valid[k] = 1'b1;
    fin_tag[k*5 +: 5] = 5'(tag);
    fin_uop[k*2 +: 2] = 2'(uop);
    fin_exc[k] = exc;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 empty", tbl_empty, 1); chk("R1 full", tbl_full, 0);
    chk("R1 ready", alloc_ready, 1); chk("R1 tag", alloc_tag, 0); chk("R1 cmp", cmp_valid, 0);

    // Vector table: one group per vector
    for (int v = 0; v < 8; v++) begin
      int tag, s;
      logic [2:0] m;
      m = VECS[v].mask;
      chk("R2 tag seq", alloc_tag, exp_tag);
      tag = exp_tag;
      alloc_valid = 1'b1; alloc_mask = m;
      tick();
      alloc_valid = 1'b0;
      exp_tag = (exp_tag + 1) % N;
      s = 0;
      for (int u = 0; u < 3; u++)
        if (VECS[v].first[u]) begin add_fin(s, tag, u, VECS[v].exc && s == 0); s++; end
      add_fin(s, tag, 3, 1'b1); s++;                 // R7 out-of-range position, exc ignored
      if (m != 3'b111)
        for (int u = 0; u < 3; u++)
          if (!m[u] && s < 5) begin add_fin(s, tag, u, 1'b1); s++; end  // R7 unused position
      tick(); clr_fin();
      chk("R4 not before next edge", cmp_valid, 0);
      tick();
      if ((VECS[v].first & m) != m) begin
        chk("R4 partial held", cmp_valid, 0);
        s = 0;
        for (int u = 0; u < 3; u++)
          if (m[u] && !VECS[v].first[u]) begin add_fin(s, tag, u, 1'b0); s++; end
        tick(); clr_fin();
        chk("R4 not before next edge", cmp_valid, 0);
        tick();
      end
      chk("R4 retired", cmp_valid, 1);
      chk("R11 cmp tag", cmp_tag, tag);
      chk("R7 R9 exc flag", cmp_exc, VECS[v].exc);
      chk("R6 table empty", tbl_empty, 1);
      tick();
      chk("R6 single pulse", cmp_valid, 0);
    end

    // R10 flush resets tags
    flush = 1'b1; tick(); flush = 1'b0;
    chk("R10 tag zero", alloc_tag, 0); chk("R10 empty", tbl_empty, 1);

    // R2/R3 fill the table
    alloc_valid = 1'b1; alloc_mask = 3'b001;
    for (int i = 0; i < N; i++) begin
      chk("R2 fill tag", alloc_tag, i);
      tick();
    end
    chk("R3 full", tbl_full, 1); chk("R3 ready low", alloc_ready, 0);
    tick();
    alloc_valid = 1'b0;
    chk("R3 stays full", tbl_full, 1); chk("R3 tag held", alloc_tag, 0);

    // R5 younger finished first waits
    add_fin(0, 1, 0, 1'b0); tick(); clr_fin(); tick();
    chk("R5 younger waits", cmp_valid, 0);
    add_fin(0, 0, 0, 1'b0); tick(); clr_fin(); tick();
    chk("R5 head retires", cmp_valid, 1); chk("R5 head tag", cmp_tag, 0);
    tick();
    chk("R6 next retires", cmp_valid, 1); chk("R6 next tag", cmp_tag, 1);
    tick();
    chk("R6 idle", cmp_valid, 0);

    // R8 five reports in one cycle
    for (int k = 0; k < 5; k++) add_fin(k, 2 + k, 0, 1'b0);
    tick(); clr_fin();
    for (int j = 0; j < 5; j++) begin
      tick();
      chk("R8 R6 retire", cmp_valid, 1); chk("R8 retire tag", cmp_tag, 2 + j);
    end
    chk("R3 ready again", alloc_ready, 1); chk("R3 not full", tbl_full, 0);

    // R9 exception discards younger
    add_fin(0, 7, 0, 1'b1); add_fin(1, 8, 0, 1'b0);
    tick(); clr_fin();
    chk("R9 ready low", alloc_ready, 0);
    tick();
    chk("R9 retire", cmp_valid, 1); chk("R9 exc", cmp_exc, 1); chk("R9 tag", cmp_tag, 7);
    chk("R9 empty", tbl_empty, 1); chk("R9 next tag", alloc_tag, 8);
    tick();
    chk("R9 younger gone", cmp_valid, 0);

    // R10 flush beats a ready retirement
    alloc_valid = 1'b1; alloc_mask = 3'b001; tick(); tick(); alloc_valid = 1'b0;
    add_fin(0, 8, 0, 1'b0); tick(); clr_fin();
    flush = 1'b1; tick(); flush = 1'b0;
    chk("R10 no cmp", cmp_valid, 0); chk("R10 empty", tbl_empty, 1); chk("R10 tag", alloc_tag, 0);
    tick();
    chk("R10 still no cmp", cmp_valid, 0);

    // R7 report to unoccupied slot
    add_fin(0, 0, 0, 1'b1); tick(); clr_fin(); tick();
    chk("R7 unoccupied", cmp_valid, 0); chk("R7 still empty", tbl_empty, 1);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule